// File: doc/BRIEF.md
# Two-Level Interrupt Status Controller

This block collects interrupt events for a flash-card host controller and turns them into one interrupt line. Each event source delivers a single-cycle pulse that sets a bit in a local status register. A local enable register selects which of those bits may raise a request. The enabled requests feed bit 0 of a global status register. A second, sibling controller shares that global register through its bit 1.

Two separate global gates follow. The status-enable gate decides whether requests are recorded in the global status register at all. The signal-enable gate decides whether a recorded global bit drives the interrupt output. Software reads and clears every register through a simple register port. Read data appears one cycle after the read strobe. Status bits in both levels are cleared by writing ones to them.

Top module: `cfh_irq_unit`

## Requirements
- R1: After reset, every register reads as zero and `irq_out` is 0.
- R2: A pulse on `ev_pulse[i]` sets local status bit i at the next clock edge, whatever the local enable holds. Only bits 0-3 and 8-11 exist (mask 0xF0F), and they sit at these positions: card detect 0, status change 1, memory mode 2, I/O mode 3, IDE mode 8, transfer error 9, buffer available 10, transfer done 11.
- R3: A write to local status (offset 0x004) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: If an event pulse and a write-one clear hit the same local status bit in one cycle, the bit ends up set.
- R5: Local status and local enable (offset 0x008) hold only the bits in mask 0xF0F. Other bits read 0 and writes to them are ignored.
- R6: Global status bit 0 (offset 0x800) is set one cycle after the following three conditions hold together: some local status bit is set, that bit is also enabled, and global status-enable (offset 0x804, bit 0) is 1. If any of these is missing, bit 0 is not set.
- R7: A pulse on `sib_pulse` sets global status bit 1 at the next edge, but only when global status-enable is 1.
- R8: Writing 1 to a global status bit clears it. For bit 0 the set condition of R6 wins over the clear when both hold in the same cycle.
- R9: `irq_out` is registered. It equals, one cycle later, the AND of global signal-enable (offset 0x808, bit 0) with the OR of the global status bits.
- R10: Read data is valid one cycle after `rd_en`. Addresses that are not mapped read zero. The two global enable registers read back only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse | input | 12 | Single-cycle local event pulses, one per status bit |
| sib_pulse | input | 1 | Request pulse from the sibling controller |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| irq_out | output | 1 | Registered interrupt line |

## Verification
The bench builds the block with its default parameters: 12-bit offsets and a 32-bit data path. With these defaults all five offsets are reachable, and the unused upper data bits can be written so the bench can show they are dropped. The table drives event patterns that mix implemented and unimplemented bit positions against assorted enable masks. Directed sequences then cover the three-cycle path from event to interrupt line, the clear/set collisions at both levels, and each global gate on its own.

// File: rtl/cfh_irq_pkg.sv
package cfh_irq_pkg;
  localparam int LOCAL_W = 12;
  localparam int GLOB_W  = 2;
  localparam logic [LOCAL_W-1:0] LOCAL_VALID = 12'hF0F;
  localparam logic [11:0] OFS_LSTAT = 12'h004;
  localparam logic [11:0] OFS_LEN   = 12'h008;
  localparam logic [11:0] OFS_GSTAT = 12'h800;
  localparam logic [11:0] OFS_GSTEN = 12'h804;
  localparam logic [11:0] OFS_GSGEN = 12'h808;
endpackage

// File: rtl/cfh_irq_local.sv
module cfh_irq_local
  import cfh_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [LOCAL_W-1:0] ev,
  input  logic               clr_wr,
  input  logic               en_wr,
  input  logic [LOCAL_W-1:0] wbits,
  output logic [LOCAL_W-1:0] lstat,
  output logic [LOCAL_W-1:0] len,
  output logic               pend
);
  logic [LOCAL_W-1:0] clr_mask;

  assign clr_mask = clr_wr ? wbits : '0;

  genvar i;
  generate
    for (i = 0; i < LOCAL_W; i++) begin : g_bit
      if (LOCAL_VALID[i]) begin : g_impl
        always_ff @(posedge clk) begin
          if (rst) begin
            lstat[i] <= 1'b0;
            len[i]   <= 1'b0;
          end else begin
            // set has priority over write-one clear
            lstat[i] <= ev[i] | (lstat[i] & ~clr_mask[i]);
            if (en_wr) len[i] <= wbits[i];
          end
        end
      end else begin : g_none
        assign lstat[i] = 1'b0;
        assign len[i]   = 1'b0;
      end
    end
  endgenerate

  assign pend = |(lstat & len);
endmodule

// File: rtl/cfh_irq_global.sv
module cfh_irq_global
  import cfh_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pend,
  input  logic              sib,
  input  logic              gs_wr,
  input  logic              gsten_wr,
  input  logic              gsgen_wr,
  input  logic [GLOB_W-1:0] wbits,
  output logic [GLOB_W-1:0] gstat,
  output logic              gsten,
  output logic              gsgen,
  output logic              irq
);
  logic [GLOB_W-1:0] set_v;
  logic [GLOB_W-1:0] clr_v;

  assign set_v = {sib, pend} & {GLOB_W{gsten}};
  assign clr_v = gs_wr ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      gstat <= '0;
      gsten <= 1'b0;
      gsgen <= 1'b0;
      irq   <= 1'b0;
    end else begin
      gstat <= set_v | (gstat & ~clr_v);
      if (gsten_wr) gsten <= wbits[0];
      if (gsgen_wr) gsgen <= wbits[0];
      irq <= gsgen & (|gstat);
    end
  end
endmodule

// File: rtl/cfh_irq_readmux.sv
module cfh_irq_readmux
  import cfh_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [LOCAL_W-1:0] lstat,
  input  logic [LOCAL_W-1:0] len,
  input  logic [GLOB_W-1:0]  gstat,
  input  logic               gsten,
  input  logic               gsgen,
  output logic [DATA_W-1:0]  rd_data
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    case (addr)
      ADDR_W'(OFS_LSTAT): sel[LOCAL_W-1:0] = lstat;
      ADDR_W'(OFS_LEN):   sel[LOCAL_W-1:0] = len;
      ADDR_W'(OFS_GSTAT): sel[GLOB_W-1:0]  = gstat;
      ADDR_W'(OFS_GSTEN): sel[0]           = gsten;
      ADDR_W'(OFS_GSGEN): sel[0]           = gsgen;
      default:            sel              = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel;
  end
endmodule

// File: rtl/cfh_irq_unit.sv
module cfh_irq_unit
  import cfh_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LOCAL_W-1:0] ev_pulse,
  input  logic               sib_pulse,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq_out
);
  logic [LOCAL_W-1:0] lstat_q;
  logic [LOCAL_W-1:0] len_q;
  logic [GLOB_W-1:0]  gstat_q;
  logic               gsten_q;
  logic               gsgen_q;
  logic               pend;
  logic               wr_lstat, wr_len, wr_gstat, wr_gsten, wr_gsgen;

  assign wr_lstat = wr_en && (addr == ADDR_W'(OFS_LSTAT));
  assign wr_len   = wr_en && (addr == ADDR_W'(OFS_LEN));
  assign wr_gstat = wr_en && (addr == ADDR_W'(OFS_GSTAT));
  assign wr_gsten = wr_en && (addr == ADDR_W'(OFS_GSTEN));
  assign wr_gsgen = wr_en && (addr == ADDR_W'(OFS_GSGEN));

  cfh_irq_local u_local (
    .clk   (clk),
    .rst   (rst),
    .ev    (ev_pulse),
    .clr_wr(wr_lstat),
    .en_wr (wr_len),
    .wbits (wr_data[LOCAL_W-1:0]),
    .lstat (lstat_q),
    .len   (len_q),
    .pend  (pend)
  );

  cfh_irq_global u_global (
    .clk     (clk),
    .rst     (rst),
    .pend    (pend),
    .sib     (sib_pulse),
    .gs_wr   (wr_gstat),
    .gsten_wr(wr_gsten),
    .gsgen_wr(wr_gsgen),
    .wbits   (wr_data[GLOB_W-1:0]),
    .gstat   (gstat_q),
    .gsten   (gsten_q),
    .gsgen   (gsgen_q),
    .irq     (irq_out)
  );

  cfh_irq_readmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .addr   (addr),
    .lstat  (lstat_q),
    .len    (len_q),
    .gstat  (gstat_q),
    .gsten  (gsten_q),
    .gsgen  (gsgen_q),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/cfh_irq_chk.sv
module cfh_irq_chk
  import cfh_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [LOCAL_W-1:0] ev_pulse,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic [DATA_W-1:0]  rd_data,
  input logic [LOCAL_W-1:0] lstat,
  input logic [LOCAL_W-1:0] len,
  input logic [GLOB_W-1:0]  gstat,
  input logic               gsten,
  input logic               gsgen,
  input logic               irq_out
);
  logic [LOCAL_W-1:0] ev_v;
  logic               wr_ls;
  logic               mapped;

  assign ev_v   = ev_pulse & LOCAL_VALID;
  assign wr_ls  = wr_en && (addr == ADDR_W'(OFS_LSTAT));
  assign mapped = (addr == ADDR_W'(OFS_LSTAT)) || (addr == ADDR_W'(OFS_LEN)) ||
                  (addr == ADDR_W'(OFS_GSTAT)) || (addr == ADDR_W'(OFS_GSTEN)) ||
                  (addr == ADDR_W'(OFS_GSGEN));

  assert_evset_R2: assert property (@(posedge clk) disable iff (rst)
    (|ev_v) |=> ((lstat & $past(ev_v)) == $past(ev_v)));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_ls && ((ev_pulse & wr_data[LOCAL_W-1:0]) == '0))
      |=> ((lstat & $past(wr_data[LOCAL_W-1:0])) == '0));

  assert_setwins_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_ls && |(ev_v & wr_data[LOCAL_W-1:0]))
      |=> ((lstat & $past(ev_v & wr_data[LOCAL_W-1:0])) != '0));

  assert_unused_R5: assert property (@(posedge clk) disable iff (rst)
    (((lstat | len) & ~LOCAL_VALID) == '0));

  assert_gset_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(gstat[0]) |-> $past(gsten && |(lstat & len)));

  assert_irq_R9: assert property (@(posedge clk) disable iff (rst)
    irq_out == $past(gsgen && (|gstat)));

  assert_rdzero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> (rd_data == '0));
endmodule

bind cfh_irq_unit cfh_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .lstat(lstat_q),
  .len(len_q), .gstat(gstat_q), .gsten(gsten_q), .gsgen(gsgen_q),
  .irq_out(irq_out)
);

// File: tb/cfh_irq_unit_tb.sv
module cfh_irq_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] VMASK = 12'hF0F;
  localparam logic [11:0] A_LS = 12'h004, A_LE = 12'h008, A_GS = 12'h800,
                          A_GE = 12'h804, A_GG = 12'h808;
  // each entry: {event pattern, local enable pattern}
  localparam int NVEC = 8;
  localparam logic [23:0] VEC [NVEC] = '{
    {12'h001, 12'h001}, {12'h0F0, 12'hFFF}, {12'h800, 12'h400},
    {12'hF0F, 12'h000}, {12'h200, 12'h200}, {12'h104, 12'h100},
    {12'h030, 12'h030}, {12'h402, 12'h002}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] ev_pulse = '0;
  logic        sib_pulse = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfh_irq_unit u_dut (
    .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .sib_pulse(sib_pulse),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_out(irq_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic pulse(logic [11:0] e);
    @(negedge clk); ev_pulse = e;
    @(negedge clk); ev_pulse = '0;
  endtask

  task automatic sib();
    @(negedge clk); sib_pulse = 1'b1;
    @(negedge clk); sib_pulse = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(A_LS, d); check("R1 lstat", d, 0);
    rd(A_LE, d); check("R1 len", d, 0);
    rd(A_GS, d); check("R1 gstat", d, 0);
    rd(A_GE, d); check("R1 gsten", d, 0);
    rd(A_GG, d); check("R1 gsgen", d, 0);
    check("R1 irq", {31'd0, irq_out}, 0);

    wr(A_GE, 1); wr(A_GG, 1);
    // table walk: R2 bit positions, R6 and R9 gating by local enable
    for (int k = 0; k < NVEC; k++) begin
      logic [11:0] e, en;
      e = VEC[k][23:12]; en = VEC[k][11:0];
      wr(A_LS, 32'hFFF); wr(A_GS, 3); wr(A_LE, {20'd0, en});
      pulse(e); wait_cyc(2);
      check("R9 irq vec", {31'd0, irq_out}, {31'd0, |(e & en & VMASK)});
      rd(A_LS, d); check("R2 lstat vec", d, {20'd0, e & VMASK});
    end

    // R3 partial clear
    wr(A_LS, 32'hFFF); pulse(12'hF0F); wr(A_LS, 32'h00F);
    rd(A_LS, d); check("R3 partial w1c", d, 32'hF00);
    // R4 set and clear collide on bit 9
    wr(A_LS, 32'hFFF);
    @(negedge clk); ev_pulse = 12'h200; wr_en = 1'b1; addr = A_LS; wr_data = 32'h200;
    @(negedge clk); ev_pulse = '0; wr_en = 1'b0;
    rd(A_LS, d); check("R4 set wins", d, 32'h200);
    // R5 unused enable bits
    wr(A_LE, 32'hFFFF_FFFF); rd(A_LE, d); check("R5 len mask", d, 32'hF0F);

    // R6 status-enable gate
    wr(A_LS, 32'hFFF); wr(A_GS, 3); wr(A_GE, 0); wr(A_LE, 1);
    pulse(12'h001); wait_cyc(2);
    rd(A_GS, d); check("R6 gated off", d, 0);
    check("R6 irq off", {31'd0, irq_out}, 0);
    wr(A_GE, 1); wait_cyc(1);
    rd(A_GS, d); check("R6 set", d, 1);
    // R8 set wins over clear while local pending
    wr(A_GS, 1); rd(A_GS, d); check("R8 bit0 held", d, 1);
    wr(A_LS, 32'hFFF); wr(A_GS, 1); rd(A_GS, d); check("R8 bit0 cleared", d, 0);
    // R7 sibling bit
    sib(); wait_cyc(1);
    rd(A_GS, d); check("R7 sibling", d, 2);
    check("R9 irq sibling", {31'd0, irq_out}, 1);
    wr(A_GS, 2); wait_cyc(2);
    rd(A_GS, d); check("R8 bit1 cleared", d, 0);
    check("R9 irq drop", {31'd0, irq_out}, 0);
    wr(A_GE, 0); sib(); wait_cyc(1);
    rd(A_GS, d); check("R7 gated off", d, 0);
    // R9 signal-enable gate
    wr(A_GE, 1); wr(A_GG, 0); sib(); wait_cyc(2);
    check("R9 irq masked", {31'd0, irq_out}, 0);
    rd(A_GS, d); check("R9 status kept", d, 2);
    wr(A_GG, 1); wait_cyc(2);
    check("R9 irq unmasked", {31'd0, irq_out}, 1);
    // R10 unmapped read and global enable width
    rd(12'h00C, d); check("R10 unmapped", d, 0);
    wr(A_GG, 32'hFFFF); rd(A_GG, d); check("R10 gsgen width", d, 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule